// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned or two's-complement operands and a carry-in, and returns the sum, the carry out of the top bit and a signed overflow flag. It is purely combinational, with no clock and no reset. Any registering of the inputs or outputs is left to the design around it.

The operand is split into fixed-size blocks, eight bits each by default, which gives four blocks at the default 32-bit width. Each block forms per-bit generate (AND) and propagate (OR) terms. Every carry inside a block is computed as a flat sum of products from those terms and the block's carry-in, so no carry ripples inside a block. Each block also reports a group generate and a group propagate term.

A second lookahead level turns the group pairs and the external carry-in into the carry into every block and the final carry-out. All of these come straight from the carry-in, in parallel. A parameter selects a variant in which the block carries ripple from one block to the next instead. This lets the two structures be checked against each other.

Top module: `cla2_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `ci`) modulo 2^WIDTH for every input combination.
- R2: `co` equals bit WIDTH of the full-width sum `a` + `b` + `ci`.
- R3: `ovf` is 1 exactly when `a[WIDTH-1]` equals `b[WIDTH-1]` and `sum[WIDTH-1]` differs from them. This is the XOR of the carry into the top bit and the carry out of it.
- R4: All ones plus one (`a`=all ones, `b`=1, `ci`=0) gives `sum`=0, `co`=1 and `ovf`=0.
- R5: The largest positive value plus one (`a`=0x7FFFFFFF, `b`=1, `ci`=0) gives `sum`=0x80000000, `co`=0 and `ovf`=1.
- R6: The most negative value added to itself (`a`=`b`=0x80000000, `ci`=0) gives `sum`=0, `co`=1 and `ovf`=1.
- R7: With `a`=all ones, `b`=0 and `ci`=1, the carry-in crosses every block: `sum`=0, `co`=1 and `ovf`=0.
- R8: With CARRY_MODE=1 (block-to-block ripple), the outputs equal those of CARRY_MODE=0 (second-level lookahead) for every input.
- R9: Outputs depend only on the present inputs. There is no state, and a new result is valid in the same cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| co | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Signed overflow flag |

## Verification
Every result is combinational, so sum, carry-out and overflow are due in the same cycle as the inputs that produce them, with no register on the path. The bench drives each new operand pair on a rising edge and samples all outputs at the following falling edge, half a cycle later. This leaves the whole lookahead path settled, and no later input change is involved. An 8-bit, 4-bit-block configuration is swept over all operand and carry-in combinations in both carry modes. The 32-bit instances get the named corner cases and random operands.

// File: rtl/cla2_adder.sv
module cla2_adder #(
  parameter int WIDTH      = 32,
  parameter int BLK        = 8,
  parameter int CARRY_MODE = 0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             co,
  output logic             ovf
);
  localparam int NBLK = WIDTH / BLK;

  function automatic logic carry_sop(input logic [WIDTH-1:0] gv,
                                     input logic [WIDTH-1:0] pv,
                                     input logic cin, input int n);
    logic acc, term;
    acc = 1'b0;
    for (int j = 0; j < WIDTH; j++) begin
      if (j < n) begin
        term = gv[j];
        for (int m = 0; m < WIDTH; m++)
          if (m > j && m < n) term = term & pv[m];
        acc = acc | term;
      end
    end
    term = cin;
    for (int m = 0; m < WIDTH; m++)
      if (m < n) term = term & pv[m];
    return acc | term;
  endfunction

  logic [WIDTH-1:0] g, p, cbit;
  logic [NBLK-1:0]  grp_g, grp_p;
  logic [NBLK:0]    blk_c;

  assign g = a & b;
  assign p = a | b;
  assign blk_c[0] = ci;

  for (genvar j = 0; j < NBLK; j++) begin : g_blk
    logic [BLK-1:0] bg, bp, cc;
    assign bg = g[j*BLK +: BLK];
    assign bp = p[j*BLK +: BLK];
    assign grp_p[j] = &bp;
    assign grp_g[j] = carry_sop(WIDTH'(bg), WIDTH'(bp), 1'b0, BLK);
    assign cc[0] = blk_c[j];
    for (genvar k = 1; k < BLK; k++) begin : g_bit
      assign cc[k] = carry_sop(WIDTH'(bg), WIDTH'(bp), blk_c[j], k);
    end
    assign cbit[j*BLK +: BLK] = cc;

    if (CARRY_MODE == 0) begin : g_look
      assign blk_c[j+1] = carry_sop(WIDTH'(grp_g), WIDTH'(grp_p), ci, j + 1);
    end else begin : g_rip
      assign blk_c[j+1] = grp_g[j] | (grp_p[j] & blk_c[j]);
    end
  end

  assign sum = a ^ b ^ cbit;
  assign co  = blk_c[NBLK];
  assign ovf = cbit[WIDTH-1] ^ blk_c[NBLK];
endmodule

// File: rtl/cla2_adder_chk.sv
module cla2_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             ci,
  input logic [WIDTH-1:0] sum,
  input logic             co,
  input logic             ovf
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] MINN = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MAXP = ~MINN;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};

  always_comb begin
    p_sum_r1: assert (sum == ref_sum[WIDTH-1:0]);
    p_cout_r2: assert (co == ref_sum[WIDTH]);
    p_ovf_r3: assert (ovf == ((a[WIDTH-1] == b[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1])));
    if (a == ONES && b == ONE && !ci)
      p_wrap_r4: assert (sum == '0 && co && !ovf);
    if (a == MAXP && b == ONE && !ci)
      p_posov_r5: assert (sum == MINN && !co && ovf);
    if (a == MINN && b == MINN && !ci)
      p_negov_r6: assert (sum == '0 && co && ovf);
    if (a == ONES && b == '0 && ci)
      p_cin_r7: assert (sum == '0 && co && !ovf);
  end
endmodule

bind cla2_adder cla2_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .ci(ci), .sum(sum), .co(co), .ovf(ovf)
);

// File: tb/sim_cla2_adder.sv
module sim_cla2_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  logic [31:0] a32, b32; logic ci32;
  logic [31:0] s_la, s_rp; logic co_la, co_rp, ov_la, ov_rp;
  logic [7:0]  a8, b8; logic ci8;
  logic [7:0]  s8_la, s8_rp; logic co8_la, co8_rp, ov8_la, ov8_rp;

  cla2_adder #(.WIDTH(32), .BLK(8), .CARRY_MODE(0)) u0 (
    .a(a32), .b(b32), .ci(ci32), .sum(s_la), .co(co_la), .ovf(ov_la));
  cla2_adder #(.WIDTH(32), .BLK(8), .CARRY_MODE(1)) u_rip32 (
    .a(a32), .b(b32), .ci(ci32), .sum(s_rp), .co(co_rp), .ovf(ov_rp));
  cla2_adder #(.WIDTH(8), .BLK(4), .CARRY_MODE(0)) u_la8 (
    .a(a8), .b(b8), .ci(ci8), .sum(s8_la), .co(co8_la), .ovf(ov8_la));
  cla2_adder #(.WIDTH(8), .BLK(4), .CARRY_MODE(1)) u_rp8 (
    .a(a8), .b(b8), .ci(ci8), .sum(s8_rp), .co(co8_rp), .ovf(ov8_rp));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive32(input logic [31:0] x, input logic [31:0] y, input logic c);
    @(posedge clk);
    a32 = x; b32 = y; ci32 = c;
    @(negedge clk);
  endtask

  task automatic check32(input string tag);
    logic [32:0] e;
    logic eo;
    e  = {1'b0, a32} + {1'b0, b32} + {32'b0, ci32};
    eo = (a32[31] == b32[31]) && (e[31] != a32[31]);
    chk({tag, " R1 sum"}, 64'(s_la), 64'(e[31:0]));
    chk({tag, " R2 co"}, 64'(co_la), 64'(e[32]));
    chk({tag, " R3 ovf"}, 64'(ov_la), 64'(eo));
    chk({tag, " R8 ripple match"}, {31'b0, co_rp, ov_rp, s_rp}, {31'b0, co_la, ov_la, s_la});
  endtask

  initial begin
    a32 = '0; b32 = '0; ci32 = 1'b0; a8 = '0; b8 = '0; ci8 = 1'b0;
    @(negedge clk);
    chk("R9 idle zero inputs", {31'b0, co_la, ov_la, s_la}, 64'd0);

    drive32(32'hFFFF_FFFF, 32'h1, 1'b0);
    chk("R4 sum", 64'(s_la), 64'd0); chk("R4 co", 64'(co_la), 64'd1); chk("R4 ovf", 64'(ov_la), 64'd0);
    check32("R4");
    drive32(32'h7FFF_FFFF, 32'h1, 1'b0);
    chk("R5 sum", 64'(s_la), 64'h8000_0000); chk("R5 co", 64'(co_la), 64'd0); chk("R5 ovf", 64'(ov_la), 64'd1);
    check32("R5");
    drive32(32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R6 sum", 64'(s_la), 64'd0); chk("R6 co", 64'(co_la), 64'd1); chk("R6 ovf", 64'(ov_la), 64'd1);
    check32("R6");
    drive32(32'hFFFF_FFFF, 32'h0, 1'b1);
    chk("R7 sum", 64'(s_la), 64'd0); chk("R7 co", 64'(co_la), 64'd1); chk("R7 ovf", 64'(ov_la), 64'd0);
    check32("R7");
    drive32(32'h00FF_00FF, 32'h0000_FF01, 1'b0);
    chk("R9 same-cycle result", 64'(s_la), 64'h0100_0000);

    for (int i = 0; i < 3000; i++) begin
      drive32($urandom, $urandom, 1'($urandom));
      check32("rand32");
    end

    for (int v = 0; v < 131072; v++) begin
      logic [8:0] e8;
      logic eo8;
      @(posedge clk);
      a8 = v[7:0]; b8 = v[15:8]; ci8 = v[16];
      @(negedge clk);
      e8  = {1'b0, a8} + {1'b0, b8} + {8'b0, ci8};
      eo8 = (a8[7] == b8[7]) && (e8[7] != a8[7]);
      chk("sweep8 R1 R2 R3", {54'b0, co8_la, ov8_la, s8_la}, {54'b0, e8[8], eo8, e8[7:0]});
      chk("sweep8 R8", {54'b0, co8_rp, ov8_rp, s8_rp}, {54'b0, co8_la, ov8_la, s8_la});
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end else if (cycles > 190000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule